// File: doc/BRIEF.md
# Ingress Packet Filter

The block stands at the entrance of an on-chip packet network and screens every packet before it may enter. Words arrive on a valid/ready stream with start and end markers. Each packet is collected into a local buffer while a running CRC is computed. When the end word is accepted, one combinational stage judges three properties: the opcode in the header is known, the word count matches that opcode, and the final word equals the CRC of the words before it. That judgement lands in the same cycle as the end word.

A packet that passes is replayed downstream word for word with its markers intact. A packet that fails is discarded whole, so not one of its words leaves the block. It also produces a one-cycle fault report that carries a reason code, a fixed source identifier and the header word, which a separate logging unit may capture. While a passing packet is replayed, the input is held off.

Top module: `pkt_ingress_filter`

## Requirements
- R1: The opcode is header bits [7:0]. Only 0x10, 0x21, 0x32 and 0x4F are known. Any other opcode rejects the packet with fault code 1.
- R2: The required total word count, counting the header and the CRC word, is 2 for 0x10, 4 for 0x21, 8 for 0x32 and 16 for 0x4F. Any other count rejects the packet with fault code 2.
- R3: The last word must equal the CRC-32 (polynomial 0x04C11DB7, seed 0xFFFFFFFF, bits processed MSB first, no reflection and no final inversion) of all earlier words of the packet. A mismatch rejects the packet with fault code 3.
- R4: When several checks fail, the code reported is the opcode failure (1) first, then the length failure (2), then the CRC failure (3).
- R5: A passing packet is forwarded with every word unchanged and in order, with the start marker on the first word and the end marker on the last. While out_ready is low the presented word and its markers stay steady.
- R6: A rejected packet puts no word on the output at all.
- R7: Each rejection raises fault_valid for exactly one cycle, the cycle after the end word is accepted. During that cycle fault_code holds the reason, fault_hdr holds the packet's first word and fault_src holds the SRC_ID parameter.
- R8: From the cycle after a pass verdict until the last forwarded word is taken, in_ready is low. It returns high in the next cycle. During a fault cycle in_ready stays high.
- R9: A word carrying the start marker always opens a new packet and silently drops any unfinished one. A word that arrives with no packet open and without a start marker is discarded.
- R10: After reset, in_ready is 1, out_valid is 0 and fault_valid is 0.
- R11: A packet longer than the buffer depth of 16 words is rejected with fault code 2, and the next packet is handled normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Filter can take an input word |
| in_data | input | 32 | Input word |
| in_sop | input | 1 | Input word is the first of a packet |
| in_eop | input | 1 | Input word is the last of a packet |
| out_valid | output | 1 | Forwarded word present |
| out_ready | input | 1 | Downstream takes the forwarded word |
| out_data | output | 32 | Forwarded word |
| out_sop | output | 1 | Forwarded word is the first of its packet |
| out_eop | output | 1 | Forwarded word is the last of its packet |
| fault_valid | output | 1 | One-cycle rejection report |
| fault_code | output | 2 | Reason: 1 opcode, 2 length, 3 CRC |
| fault_src | output | 8 | Fixed identifier of this filter |
| fault_hdr | output | 32 | Header word of the rejected packet |

## Verification
The fault report of a rejected packet and the acceptance of the next packet's header can fall in the same cycle, because in_ready stays high while fault_valid is up. The bench provokes this by sending a bad-opcode packet immediately followed by a good packet with no idle gap between them. It then judges that the report still carries the old header and code, and that the new packet is forwarded intact. A checker also asserts that forwarding and fault reporting never overlap.

// File: rtl/pkt_filter_pkg.sv
package pkt_filter_pkg;

  localparam int WORD_W = 32;
  localparam int OPC_W  = 8;
  localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_OPCODE = 2'd1,
    FLT_LENGTH = 2'd2,
    FLT_CRC    = 2'd3
  } fault_code_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_SEND    = 2'd2
  } filt_state_e;

  // Required total word count per opcode; zero marks an unknown opcode.
  function automatic logic [7:0] op_len(input logic [OPC_W-1:0] opc);
    case (opc)
      8'h10:   return 8'd2;
      8'h21:   return 8'd4;
      8'h32:   return 8'd8;
      8'h4F:   return 8'd16;
      default: return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/pkt_crc_acc.sv
module pkt_crc_acc
  import pkt_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] crc
);

  logic [WORD_W-1:0] crc_q, crc_d, base;
  logic              crc_en;

  function automatic logic [WORD_W-1:0] crc_fold(input logic [WORD_W-1:0] c,
                                                 input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    logic              fb;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[WORD_W-1] ^ w[i];
      r  = {r[WORD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction

  assign crc_en = load | step;

  always_comb begin
    base  = load ? CRC_SEED : crc_q;
    crc_d = crc_fold(base, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/pkt_frame_store.sv
module pkt_frame_store
  import pkt_filter_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/pkt_verdict.sv
module pkt_verdict
  import pkt_filter_pkg::*;
#(
  parameter int CNT_W = 5
)(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [CNT_W-1:0]  total_cnt,
  input  logic [WORD_W-1:0] crc_word,
  input  logic [WORD_W-1:0] crc_calc,
  output logic              pass,
  output fault_code_e       code
);

  logic [7:0] exp_len;
  logic       opc_ok, len_ok, crc_ok;

  assign exp_len = op_len(opcode);
  assign opc_ok  = (exp_len != 8'd0);
  assign len_ok  = (int'(total_cnt) == int'(exp_len));
  assign crc_ok  = (crc_word == crc_calc);

  // Priority: opcode, then length, then CRC.
  always_comb begin
    if (!opc_ok)      code = FLT_OPCODE;
    else if (!len_ok) code = FLT_LENGTH;
    else if (!crc_ok) code = FLT_CRC;
    else              code = FLT_NONE;
  end

  assign pass = (code == FLT_NONE);

endmodule

// File: rtl/pkt_ingress_filter.sv
module pkt_ingress_filter
  import pkt_filter_pkg::*;
#(
  parameter int                MAX_WORDS = 16,
  parameter int                SRC_W     = 8,
  parameter logic [SRC_W-1:0]  SRC_ID    = 'h3C
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              fault_valid,
  output logic [1:0]        fault_code,
  output logic [SRC_W-1:0]  fault_src,
  output logic [WORD_W-1:0] fault_hdr
);

  localparam int IDX_W   = $clog2(MAX_WORDS);
  localparam int CNT_W   = $clog2(MAX_WORDS + 2);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  filt_state_e       state_q, state_d;
  logic [CNT_W-1:0]  wr_cnt_q, wr_cnt_d;
  logic [CNT_W-1:0]  send_len_q, send_len_d;
  logic [IDX_W-1:0]  rd_idx_q, rd_idx_d;
  logic [WORD_W-1:0] hdr_q;
  logic              flt_valid_q, flt_valid_d;
  fault_code_e       flt_code_q, flt_code_d;

  logic              accept, start_w, cont_w, take_w, close_w, grow_w;
  logic [CNT_W-1:0]  word_pos, total_cnt;
  logic [WORD_W-1:0] crc_run, crc_ref, rd_word;
  logic [OPC_W-1:0]  cur_opc;
  logic              chk_pass, store_en, last_out, hdr_en, code_en;
  fault_code_e       chk_code;

  // ---------------- input acceptance ----------------
  assign in_ready  = (state_q != ST_SEND);
  assign accept    = in_valid & in_ready;
  assign start_w   = accept & in_sop;
  assign cont_w    = accept & ~in_sop & (state_q == ST_COLLECT);
  assign take_w    = start_w | cont_w;
  assign close_w   = take_w & in_eop;
  assign grow_w    = take_w & ~in_eop;

  assign word_pos  = start_w ? '0 : wr_cnt_q;
  assign total_cnt = (word_pos == CNT_W'(CNT_MAX)) ? word_pos : word_pos + CNT_W'(1);
  assign store_en  = take_w & (int'(word_pos) < MAX_WORDS);
  assign crc_ref   = start_w ? CRC_SEED : crc_run;
  assign cur_opc   = start_w ? in_data[OPC_W-1:0] : hdr_q[OPC_W-1:0];
  assign hdr_en    = start_w;
  assign code_en   = close_w;

  pkt_crc_acc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_w),
    .step  (cont_w),
    .data  (in_data),
    .crc   (crc_run)
  );

  pkt_frame_store #(.DEPTH(MAX_WORDS)) u_store (
    .clk     (clk),
    .wr_en   (store_en),
    .wr_idx  (word_pos[IDX_W-1:0]),
    .wr_data (in_data),
    .rd_idx  (rd_idx_q),
    .rd_data (rd_word)
  );

  pkt_verdict #(.CNT_W(CNT_W)) u_verdict (
    .opcode    (cur_opc),
    .total_cnt (total_cnt),
    .crc_word  (in_data),
    .crc_calc  (crc_ref),
    .pass      (chk_pass),
    .code      (chk_code)
  );

  assign last_out = (CNT_W'(rd_idx_q) == send_len_q - CNT_W'(1));

  // ---------------- next state ----------------
  always_comb begin
    state_d     = state_q;
    wr_cnt_d    = wr_cnt_q;
    send_len_d  = send_len_q;
    rd_idx_d    = rd_idx_q;
    flt_valid_d = 1'b0;
    flt_code_d  = chk_code;
    unique case (state_q)
      ST_IDLE, ST_COLLECT: begin
        if (close_w) begin
          wr_cnt_d = '0;
          if (chk_pass) begin
            state_d    = ST_SEND;
            send_len_d = total_cnt;
            rd_idx_d   = '0;
          end else begin
            state_d     = ST_IDLE;
            flt_valid_d = 1'b1;
          end
        end else if (grow_w) begin
          state_d  = ST_COLLECT;
          wr_cnt_d = total_cnt;
        end
      end
      ST_SEND: begin
        if (out_ready) begin
          if (last_out) state_d  = ST_IDLE;
          else          rd_idx_d = rd_idx_q + IDX_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wr_cnt_q    <= '0;
      send_len_q  <= '0;
      rd_idx_q    <= '0;
      flt_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      wr_cnt_q    <= wr_cnt_d;
      send_len_q  <= send_len_d;
      rd_idx_q    <= rd_idx_d;
      flt_valid_q <= flt_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q      <= '0;
      flt_code_q <= FLT_NONE;
    end else begin
      if (hdr_en)  hdr_q      <= in_data;
      if (code_en) flt_code_q <= flt_code_d;
    end
  end

  // ---------------- outputs ----------------
  assign out_valid   = (state_q == ST_SEND);
  assign out_data    = rd_word;
  assign out_sop     = (rd_idx_q == '0);
  assign out_eop     = last_out;
  assign fault_valid = flt_valid_q;
  assign fault_code  = flt_code_q;
  assign fault_src   = SRC_ID;
  assign fault_hdr   = hdr_q;

endmodule

// File: rtl/pkt_ingress_filter_chk.sv
module pkt_ingress_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_eop,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_sop,
  input logic        out_eop,
  input logic        fault_valid,
  input logic [1:0]  fault_code
);

  // R8
  fwd_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R8
  ready_after_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> in_ready);

  // R6
  fwd_excl_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !fault_valid);

  // R7
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);

  // R7
  fault_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> $past(in_valid && in_ready && in_eop));

  // R1
  fault_code_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (fault_code != 2'd0));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sop) && $stable(out_eop)));

endmodule

bind pkt_ingress_filter pkt_ingress_filter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_eop      (in_eop),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_sop     (out_sop),
  .out_eop     (out_eop),
  .fault_valid (fault_valid),
  .fault_code  (fault_code)
);

// File: tb/pkt_ingress_filter_test.sv
module pkt_ingress_filter_test;

  localparam logic [7:0]  SRC  = 8'hC7;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  // [16] priority case, [15:8] opcode, [7:3] words, [2] corrupt CRC, [1:0] expected code
  localparam logic [16:0] VEC [11] = '{
    {1'b0, 8'h10, 5'd2,  1'b0, 2'd0},
    {1'b0, 8'h21, 5'd4,  1'b0, 2'd0},
    {1'b0, 8'h32, 5'd8,  1'b0, 2'd0},
    {1'b0, 8'h4F, 5'd16, 1'b0, 2'd0},
    {1'b0, 8'h21, 5'd4,  1'b1, 2'd3},
    {1'b0, 8'h21, 5'd5,  1'b0, 2'd2},
    {1'b1, 8'h32, 5'd3,  1'b1, 2'd2},
    {1'b0, 8'h55, 5'd4,  1'b0, 2'd1},
    {1'b1, 8'h55, 5'd3,  1'b1, 2'd1},
    {1'b0, 8'h10, 5'd1,  1'b0, 2'd2},
    {1'b0, 8'h4F, 5'd15, 1'b0, 2'd2}
  };

  logic        clk, rst_n;
  logic        in_valid, in_ready, in_sop, in_eop;
  logic [31:0] in_data;
  logic        out_valid, out_ready, out_sop, out_eop;
  logic [31:0] out_data;
  logic        fault_valid;
  logic [1:0]  fault_code;
  logic [7:0]  fault_src;
  logic [31:0] fault_hdr;

  int n_chk, n_fail, cyc;

  logic [31:0] pkt [32];
  logic [31:0] fw_data [64];
  logic        fw_sop [64];
  logic        fw_eop [64];
  int          fw_n;
  logic [1:0]  ft_code [8];
  logic [31:0] ft_hdr [8];
  logic [7:0]  ft_src [8];
  int          ft_n;
  int          ovl_n;

  pkt_ingress_filter #(.SRC_ID(SRC)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop),
    .fault_valid(fault_valid), .fault_code(fault_code),
    .fault_src(fault_src), .fault_hdr(fault_hdr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  // Monitor: samples 2 ns after the falling edge, away from the active edge.
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (out_valid && out_ready && fw_n < 64) begin
        fw_data[fw_n] = out_data;
        fw_sop[fw_n]  = out_sop;
        fw_eop[fw_n]  = out_eop;
        fw_n = fw_n + 1;
      end
      if (fault_valid && ft_n < 8) begin
        ft_code[ft_n] = fault_code;
        ft_hdr[ft_n]  = fault_hdr;
        ft_src[ft_n]  = fault_src;
        ft_n = ft_n + 1;
      end
      if (out_valid && in_ready) ovl_n = ovl_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_word(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c ^ w;
    for (int b = 0; b < 32; b++) r = r[31] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  task automatic build(input logic [7:0] op, input int n, input bit bad, input logic [7:0] seed);
    logic [31:0] c;
    pkt[0] = {seed, 8'h5A, 8'(n), op};
    for (int k = 1; k < n; k++) pkt[k] = (32'(seed) * 32'h9E3779B1) + (32'(k) * 32'h01010101);
    if (n >= 2) begin
      c = 32'hFFFF_FFFF;
      for (int k = 0; k < n - 1; k++) c = crc_word(c, pkt[k]);
      pkt[n-1] = c ^ (bad ? 32'h1 : 32'h0);
    end
  endtask

  task automatic push(input logic [31:0] d, input logic s, input logic e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic send(input int n);
    for (int k = 0; k < n; k++) push(pkt[k], k == 0, k == n - 1);
  endtask

  task automatic clear_logs();
    fw_n = 0; ft_n = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  task automatic expect_pass(input string tag, input int n, input int base);
    check(fw_n == base + n, tag, "forwarded word count", fw_n, base + n);
    for (int k = 0; k < n; k++) begin
      if (base + k < fw_n) begin
        check(fw_data[base+k] == pkt[k], tag, "forwarded word", fw_data[base+k], pkt[k]);
        check(fw_sop[base+k] == (k == 0), tag, "start marker", fw_sop[base+k], k == 0);
        check(fw_eop[base+k] == (k == n - 1), tag, "end marker", fw_eop[base+k], k == n - 1);
      end
    end
  endtask

  task automatic expect_fault(input string tag, input logic [1:0] code, input logic [31:0] hdr);
    check(fw_n == 0, "R6", "words forwarded from rejected packet", fw_n, 0);
    check(ft_n == 1, "R7", "fault pulse count", ft_n, 1);
    if (ft_n >= 1) begin
      check(ft_code[0] == code, tag, "fault code", ft_code[0], code);
      check(ft_hdr[0] == hdr, "R7", "fault header", ft_hdr[0], hdr);
      check(ft_src[0] == SRC, "R7", "fault source", ft_src[0], SRC);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; ovl_n = 0;
    fw_n = 0; ft_n = 0;
    in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0;
    out_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    // R10: state held in reset
    check(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    check(fault_valid == 1'b0, "R10", "fault_valid in reset", fault_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    settle(2);
    check(in_ready == 1'b1 && out_valid == 1'b0 && fault_valid == 1'b0, "R10",
          "idle after reset", {in_ready, out_valid, fault_valid}, 3'b100);

    // Table walk
    for (int i = 0; i < 11; i++) begin
      logic [16:0] v;
      string tag;
      v = VEC[i];
      tag = v[16] ? "R4" : (v[1:0] == 2'd0 ? "R5" : v[1:0] == 2'd1 ? "R1" :
                            v[1:0] == 2'd2 ? "R2" : "R3");
      clear_logs();
      build(v[15:8], int'(v[7:3]), v[2], 8'(i + 1));
      send(int'(v[7:3]));
      idle();
      settle(30);
      if (v[1:0] == 2'd0) begin
        expect_pass(tag, int'(v[7:3]), 0);
        check(ft_n == 0, tag, "no fault for passing packet", ft_n, 0);
      end else begin
        expect_fault(tag, v[1:0], pkt[0]);
      end
    end

    // R7 and R8: fault timing, ready stays high; collision with next header
    clear_logs();
    build(8'h66, 3, 1'b0, 8'h40);
    begin
      logic [31:0] bad_hdr;
      bad_hdr = pkt[0];
      push(pkt[0], 1'b1, 1'b0);
      push(pkt[1], 1'b0, 1'b0);
      push(pkt[2], 1'b0, 1'b1);
      #2;
      check(fault_valid == 1'b1, "R7", "fault raised cycle after end word", fault_valid, 1);
      check(in_ready == 1'b1, "R8", "in_ready during fault cycle", in_ready, 1);
      build(8'h10, 2, 1'b0, 8'h41);
      send(2);
      #2;
      check(fault_valid == 1'b0, "R7", "fault pulse one cycle", fault_valid, 0);
      idle();
      settle(10);
      check(ft_n == 1, "R7", "single fault in collision", ft_n, 1);
      if (ft_n >= 1) begin
        check(ft_hdr[0] == bad_hdr, "R7", "fault header during next header", ft_hdr[0], bad_hdr);
        check(ft_code[0] == 2'd1, "R1", "collision fault code", ft_code[0], 1);
      end
      expect_pass("R5", 2, 0);
    end

    // R5 and R8: backpressure holds output and blocks input
    clear_logs();
    out_ready = 1'b0;
    build(8'h21, 4, 1'b0, 8'h50);
    send(4);
    idle();
    settle(5);
    check(out_valid == 1'b1, "R5", "word presented under backpressure", out_valid, 1);
    check(out_data == pkt[0] && out_sop == 1'b1, "R5", "first word held", out_data, pkt[0]);
    check(in_ready == 1'b0, "R8", "in_ready while forwarding", in_ready, 0);
    check(fw_n == 0, "R5", "nothing taken while stalled", fw_n, 0);
    @(negedge clk);
    out_ready = 1'b1;
    settle(10);
    expect_pass("R5", 4, 0);
    check(in_ready == 1'b1, "R8", "in_ready after forwarding", in_ready, 1);

    // R9: stray word discarded, unfinished packet abandoned by new start
    clear_logs();
    push(32'hDEAD_0021, 1'b0, 1'b0);
    build(8'h32, 8, 1'b0, 8'h60);
    push(pkt[0], 1'b1, 1'b0);
    push(pkt[1], 1'b0, 1'b0);
    build(8'h21, 4, 1'b0, 8'h61);
    send(4);
    idle();
    settle(12);
    expect_pass("R9", 4, 0);
    check(ft_n == 0, "R9", "no fault from abandoned packet", ft_n, 0);

    // R11: over-long packet then a normal one
    clear_logs();
    build(8'h4F, 18, 1'b0, 8'h70);
    send(18);
    idle();
    settle(5);
    expect_fault("R11", 2'd2, pkt[0]);
    clear_logs();
    build(8'h10, 2, 1'b0, 8'h71);
    send(2);
    idle();
    settle(6);
    expect_pass("R11", 2, 0);

    // R8: forwarding never overlapped with ready high
    check(ovl_n == 0, "R8", "cycles with out_valid and in_ready", ovl_n, 0);

    summary();
    $finish;
  end

endmodule